// File: doc/BRIEF.md
# Split-Converter Upset-Tolerant Output Selector

This block merges the two calibrated 14-bit codes of a split converter pair into one output word per sample. Each half also delivers an upset flag from an on-chip charge-event detector. When the halves agree to within a threshold, the block outputs their average, which gives about 3 dB more SNR than either half alone. When they disagree by more than the threshold and exactly one half reports an upset, the block forwards the other half. When they disagree and the flags do not identify a single culprit, the block falls back to the average and raises an error bit for that sample.

The codes and flags are captured at the clock edge where the end-of-conversion strobe is high. The result is registered one edge later and marked with a one-cycle valid strobe, so each decision takes one clock cycle. The block also issues the detector-clear pulse at the start of every sampling phase, which limits each flag to the conversion that follows. It counts substituted samples in a saturating counter. All control state (pending flag, captured upset flags, output source, error, counter, phase tracker) is held in three copies and majority-voted.

Top module: `split_sel`

## Requirements
- R1: Codes and upset flags are captured at the clock edge where `conv_done_i` is high. The result is registered at the next edge, and `valid_o` is high for the cycle that follows that edge.
- R2: If |A−B| ≤ THRESH (default 16), `code_o` = floor((A+B)/2) with no overflow at full scale, `src_o` = 2'b00 and `err_o` = 0. The upset flags have no effect in this case.
- R3: If |A−B| > THRESH and only the A flag is set, `code_o` = B and `src_o` = 2'b10.
- R4: If |A−B| > THRESH and only the B flag is set, `code_o` = A and `src_o` = 2'b01.
- R5: If |A−B| > THRESH and both flags or neither flag are set, `code_o` is the average, `src_o` = 2'b00 and `err_o` = 1.
- R6: The threshold is strict. A difference of exactly THRESH is averaged, and THRESH+1 is eligible for substitution.
- R7: `subst_cnt_o` increments by one for each result with `src_o` ≠ 2'b00 and saturates at its all-ones value.
- R8: `cnt_clr_i` clears the counter at the next edge and takes priority over an increment at that same edge.
- R9: `det_clr_o` is high for exactly one cycle, starting at the first edge where `samp_i` is high after being low.
- R10: `code_o`, `src_o` and `err_o` keep their values between results.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samp_i | input | 1 | High during the sampling phase |
| conv_done_i | input | 1 | End-of-conversion strobe; capture codes and flags |
| code_a_i | input | DW | Calibrated code of half A |
| code_b_i | input | DW | Calibrated code of half B |
| hit_a_i | input | 1 | Upset flag of half A |
| hit_b_i | input | 1 | Upset flag of half B |
| cnt_clr_i | input | 1 | Synchronous clear of the substitution counter |
| code_o | output | DW | Selected output word |
| valid_o | output | 1 | One-cycle strobe for a new result |
| src_o | output | 2 | Source: 00 average, 01 half A, 10 half B |
| err_o | output | 1 | Disagreement without a single culprit |
| subst_cnt_o | output | CNT_W | Saturating count of substituted samples |
| det_clr_o | output | 1 | Detector clear pulse |

## Verification
On every cycle, the assertions check the two-edge latency from strobe to valid, and that a substitution always follows a single-sided upset flag. They also check that an error implies the average source, that outputs hold between results, and the counter's step, saturation and clear. They also check that the clear pulse lasts one cycle. Only the directed scenarios show the arithmetic: the average value at full scale, the strict threshold boundary, and flags being ignored when the halves agree.

// File: rtl/split_sel_pkg.sv
package split_sel_pkg;
  typedef enum logic [1:0] {
    SRC_AVG = 2'b00,
    SRC_A   = 2'b01,
    SRC_B   = 2'b10
  } src_e;
endpackage

// File: rtl/tmr_reg.sv
module tmr_reg #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] cp [3];

  for (genvar g = 0; g < 3; g++) begin : g_copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cp[g] <= '0;
      else         cp[g] <= q_o == d_i ? q_o : d_i;
    end
  end

  // bitwise majority of the three copies
  assign q_o = (cp[0] & cp[1]) | (cp[0] & cp[2]) | (cp[1] & cp[2]);
endmodule

// File: rtl/half_judge.sv
module half_judge
  import split_sel_pkg::*;
#(
  parameter int DW     = 14,
  parameter int THRESH = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          hit_a_i,
  input  logic          hit_b_i,
  output logic [DW-1:0] code_o,
  output src_e          src_o,
  output logic          err_o
);
  localparam int SW = DW + 1;

  logic [SW-1:0] sum;
  logic [DW-1:0] diff;
  logic [DW-1:0] avg;
  logic          big;

  assign sum  = SW'(a_i) + SW'(b_i);
  assign avg  = sum[SW-1:1];
  assign diff = (a_i >= b_i) ? a_i - b_i : b_i - a_i;
  assign big  = 32'(diff) > THRESH;

  always_comb begin
    code_o = avg;
    src_o  = SRC_AVG;
    err_o  = 1'b0;
    if (big) begin
      if (hit_a_i && !hit_b_i) begin
        code_o = b_i;
        src_o  = SRC_B;
      end else if (hit_b_i && !hit_a_i) begin
        code_o = a_i;
        src_o  = SRC_A;
      end else begin
        err_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/split_sel.sv
module split_sel
  import split_sel_pkg::*;
#(
  parameter int DW     = 14,
  parameter int THRESH = 16,
  parameter int CNT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             samp_i,
  input  logic             conv_done_i,
  input  logic [DW-1:0]    code_a_i,
  input  logic [DW-1:0]    code_b_i,
  input  logic             hit_a_i,
  input  logic             hit_b_i,
  input  logic             cnt_clr_i,
  output logic [DW-1:0]    code_o,
  output logic             valid_o,
  output logic [1:0]       src_o,
  output logic             err_o,
  output logic [CNT_W-1:0] subst_cnt_o,
  output logic             det_clr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // capture stage
  logic [DW-1:0] a_q, b_q;
  logic          pend_q, hit_a_q, hit_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (conv_done_i) begin
      a_q <= code_a_i;
      b_q <= code_b_i;
    end
  end

  tmr_reg #(.W(3)) u_cap_ctl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({conv_done_i,
             conv_done_i ? hit_a_i : hit_a_q,
             conv_done_i ? hit_b_i : hit_b_q}),
    .q_o   ({pend_q, hit_a_q, hit_b_q})
  );

  // decision
  logic [DW-1:0] dec_code;
  src_e          dec_src;
  logic          dec_err;

  half_judge #(.DW(DW), .THRESH(THRESH)) u_judge (
    .a_i    (a_q),
    .b_i    (b_q),
    .hit_a_i(hit_a_q),
    .hit_b_i(hit_b_q),
    .code_o (dec_code),
    .src_o  (dec_src),
    .err_o  (dec_err)
  );

  // output stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_o <= '0;
    else if (pend_q) code_o <= dec_code;
  end

  tmr_reg #(.W(4)) u_out_ctl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pend_q,
             pend_q ? 2'(dec_src) : src_o,
             pend_q ? dec_err : err_o}),
    .q_o   ({valid_o, src_o, err_o})
  );

  // substitution counter
  logic [CNT_W-1:0] cnt_d;
  always_comb begin
    cnt_d = subst_cnt_o;
    if (cnt_clr_i)
      cnt_d = '0;
    else if (pend_q && dec_src != SRC_AVG && subst_cnt_o != CNT_MAX)
      cnt_d = subst_cnt_o + 1'b1;
  end

  tmr_reg #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cnt_d),
    .q_o   (subst_cnt_o)
  );

  // detector clear on sampling-phase entry
  logic samp_q;
  tmr_reg #(.W(2)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({samp_i, samp_i & ~samp_q}),
    .q_o   ({samp_q, det_clr_o})
  );

  // assertions
  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(conv_done_i, 2));

  assert_sub_b_needs_a_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && src_o == 2'b10) |-> ($past(hit_a_i, 2) && !$past(hit_b_i, 2)));

  assert_sub_a_needs_b_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && src_o == 2'b01) |-> ($past(hit_b_i, 2) && !$past(hit_a_i, 2)));

  assert_err_uses_avg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> src_o == 2'b00);

  assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_clr_i |=> (subst_cnt_o == $past(subst_cnt_o) ||
                    subst_cnt_o == CNT_W'($past(subst_cnt_o) + 1'b1)));

  assert_cnt_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (subst_cnt_o == CNT_MAX && !cnt_clr_i) |=> subst_cnt_o == CNT_MAX);

  assert_cnt_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> subst_cnt_o == '0);

  assert_det_clr_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_clr_o |=> !det_clr_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(code_o) && $stable(src_o) && $stable(err_o)));
endmodule

// File: tb/split_sel_test.sv
module split_sel_test;
  localparam int DW = 14;
  localparam int TH = 16;
  localparam int CW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          samp_i = 1'b0;
  logic          conv_done_i = 1'b0;
  logic [DW-1:0] code_a_i = '0;
  logic [DW-1:0] code_b_i = '0;
  logic          hit_a_i = 1'b0;
  logic          hit_b_i = 1'b0;
  logic          cnt_clr_i = 1'b0;
  logic [DW-1:0] code_o;
  logic          valid_o;
  logic [1:0]    src_o;
  logic          err_o;
  logic [CW-1:0] subst_cnt_o;
  logic          det_clr_o;

  int checks = 0;
  int failures = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  split_sel #(.DW(DW), .THRESH(TH), .CNT_W(CW)) uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one sample; clr_at_out drives cnt_clr_i into the output edge
  task automatic run_sample(input string tag, input int a, input int b,
                            input bit ha, input bit hb, input bit clr_at_out);
    int d, e_code, e_src, e_err;
    @(negedge clk_i);
    code_a_i = DW'(a); code_b_i = DW'(b);
    hit_a_i = ha; hit_b_i = hb; conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0; hit_a_i = 1'b0; hit_b_i = 1'b0;
    cnt_clr_i = clr_at_out;
    @(negedge clk_i);
    cnt_clr_i = 1'b0;
    d = (a > b) ? a - b : b - a;
    e_code = (a + b) / 2; e_src = 0; e_err = 0;
    if (d > TH) begin
      if (ha && !hb)      begin e_code = b; e_src = 2; end
      else if (hb && !ha) begin e_code = a; e_src = 1; end
      else                e_err = 1;
    end
    if (clr_at_out) exp_cnt = 0;
    else if (e_src != 0 && exp_cnt < (1 << CW) - 1) exp_cnt++;
    chk({tag, " R1 valid"}, int'(valid_o), 1);
    chk({tag, " code"}, int'(code_o), e_code);
    chk({tag, " src"}, int'(src_o), e_src);
    chk({tag, " err"}, int'(err_o), e_err);
    chk({tag, " R7 cnt"}, int'(subst_cnt_o), exp_cnt);
  endtask

  task automatic t_reset();
    chk("R11 code", int'(code_o), 0);
    chk("R11 valid", int'(valid_o), 0);
    chk("R11 src", int'(src_o), 0);
    chk("R11 err", int'(err_o), 0);
    chk("R11 cnt", int'(subst_cnt_o), 0);
    chk("R11 det_clr", int'(det_clr_o), 0);
  endtask

  task automatic t_quiet();
    run_sample("R2 close", 100, 110, 1'b0, 1'b0, 1'b0);
    run_sample("R2 hit ignored", 7000, 6990, 1'b1, 1'b0, 1'b0);
    run_sample("R2 full scale", 16383, 16383, 1'b1, 1'b1, 1'b0);
    run_sample("R2 odd sum", 3, 4, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_subst();
    run_sample("R3 a hit", 1000, 2000, 1'b1, 1'b0, 1'b0);
    run_sample("R4 b hit", 3000, 100, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_err();
    run_sample("R5 no flag", 0, 16383, 1'b0, 1'b0, 1'b0);
    run_sample("R5 both flags", 200, 600, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_thresh();
    run_sample("R6 at thresh", 5000, 5016, 1'b1, 1'b0, 1'b0);
    run_sample("R6 above thresh", 0, 17, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_counter();
    run_sample("R8 clear", 10, 10, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < (1 << CW) + 1; i++)
      run_sample("R7 sat", 0, 1000, 1'b0, 1'b1, 1'b0);
    chk("R7 saturated", int'(subst_cnt_o), (1 << CW) - 1);
    run_sample("R8 clear beats inc", 0, 1000, 1'b0, 1'b1, 1'b1);
    chk("R8 after clear", int'(subst_cnt_o), 0);
  endtask

  task automatic t_hold();
    run_sample("R10 setup", 4000, 9000, 1'b1, 1'b0, 1'b0);
    @(negedge clk_i);
    chk("R1 valid drops", int'(valid_o), 0);
    code_a_i = 14'd1; code_b_i = 14'd2; hit_b_i = 1'b1;
    repeat (3) @(negedge clk_i);
    hit_b_i = 1'b0;
    chk("R10 code held", int'(code_o), 9000);
    chk("R10 src held", int'(src_o), 2);
    chk("R10 err held", int'(err_o), 0);
  endtask

  task automatic t_det_clr();
    @(negedge clk_i); samp_i = 1'b1;
    @(negedge clk_i);
    chk("R9 pulse", int'(det_clr_o), 1);
    @(negedge clk_i);
    chk("R9 one cycle", int'(det_clr_o), 0);
    samp_i = 1'b0;
    @(negedge clk_i);
    chk("R9 low", int'(det_clr_o), 0);
    samp_i = 1'b1;
    @(negedge clk_i);
    chk("R9 second pulse", int'(det_clr_o), 1);
    samp_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_quiet();
    t_subst();
    t_err();
    t_thresh();
    t_counter();
    t_hold();
    t_det_clr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule